// File: doc/BRIEF.md
# SPI Master Byte-Stream Engine

This block is an SPI master that moves a run of bytes to or from a single slave device under one command. A one-cycle `start` pulse carries a direction (send or receive) and a byte count. In send mode the user offers bytes one at a time on a ready/valid stream. In both modes every byte clocked in from the slave leaves on a valid stream. Every transfer is full duplex: eight clocks move one byte out on MOSI and one byte in from MISO. In receive mode there is no user data, so the engine drives all-ones to produce the clocks.

Transmit data passes through a one-byte holding register, so the user stream can run one byte ahead of the wire. An empty holding register therefore says nothing about whether the transfer has finished. Completion is taken from the receive side instead: `done` pulses in the same cycle that the final received byte is presented.

Chip select is driven from a separate level input. Several transfers can therefore be chained inside one select window, for example an opcode sent and then a reply read back. The serial clock runs at a fixed fraction of the system clock, set by a parameter, and idles low (SPI mode 0).

Top module: `spi_stream_master`

## Requirements
- R1: After reset, `sclk` is low, `cs_n` is high, and `busy`, `done`, `rx_valid` and `tx_ready` are all low.
- R2: SPI mode 0. `sclk` is low whenever `busy` is low. `mosi` never changes while `sclk` stays high. `miso` is sampled on the rising edge of `sclk`.
- R3: In send mode (`dir_rx`=0), each byte accepted on the transmit stream goes out on `mosi` most significant bit first, in the order the bytes were accepted.
- R4: For each byte of a transfer, in either mode, exactly one `rx_valid` pulse is produced. It carries the eight bits sampled from `miso`, with the first sampled bit placed at bit 7.
- R5: In receive mode (`dir_rx`=1), `mosi` stays 1 for the whole transfer, so each byte sent is 0xFF, and `tx_ready` stays low.
- R6: `done` is a single-cycle pulse that coincides with the `rx_valid` of the final byte. It is never raised earlier, for example when the holding register empties.
- R7: The next transmit byte can be accepted while the current byte is still shifting. If no byte is available when one is needed, `sclk` holds low with no edges until a byte arrives, and the transfer then resumes correctly.
- R8: A `start` pulse that arrives while `busy` is high is ignored: it does not change the number of bytes transferred.
- R9: A `start` with a byte count of 0 raises `done` on the next cycle, does not raise `busy`, and produces no `sclk` edge.
- R10: `cs_n` is the inverse of `cs_assert`, registered once. It does not depend on transfer activity, so consecutive transfers can share one select window.
- R11: Each `sclk` period spans 2*`HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a transfer |
| dir_rx | input | 1 | Direction, sampled with `start`: 1 = receive (send 0xFF), 0 = send user bytes |
| byte_count | input | CNT_W | Number of bytes, sampled with `start` |
| cs_assert | input | 1 | Level request for the active-low chip select |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte is offered |
| tx_ready | output | 1 | Engine accepts the offered byte this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse: the final byte is fully exchanged |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the slave |

## Verification
The hardest state to reach from the ports is a stall in the middle of a send: the current byte has finished and the holding register is empty. The stimulus reaches it by handing over only the first byte and then withholding `tx_valid` for a long gap. During that gap the bench counts `sclk` edges and expects none. It then supplies the second byte and checks that the slave model received both bytes intact.

A second hard case is a `start` pulse issued in the middle of a transfer. It is driven while the first byte is shifting, and the bench confirms that the number of bytes exchanged equals the original count. A behavioural mode-0 slave on the wire captures `mosi` and shifts out a known pattern, so both directions are checked bit for bit.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } spim_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } spim_dir_e;

    // Advance the outgoing shifter by one bit, back-filling with ones so a
    // receive-only byte keeps driving high.
    function automatic logic [BYTE_W-1:0] shift_next(input logic [BYTE_W-1:0] b);
        return {b[BYTE_W-2:0], 1'b1};
    endfunction

endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R11: the divider never runs past its half-period terminal count
    assert_div_bound_R11: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/spim_txbuf.sv
module spim_txbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic         full,
    output logic [W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            rd_data <= '0;
        end else if (wr_en) begin
            full    <= 1'b1;
            rd_data <= wr_data;
        end else if (rd_en) begin
            full    <= 1'b0;
        end
    end

    // R7: the holding register is never written while it still holds a byte
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R7: a byte is only taken out when one is present
    assert_no_underrun_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> full);

endmodule

// File: rtl/spim_rxshift.sv
module spim_rxshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_en,
    input  logic         bit_in,
    output logic [W-1:0] byte_out
);
    always_ff @(posedge clk) begin
        if (rst)            byte_out <= '0;
        else if (sample_en) byte_out <= {byte_out[W-2:0], bit_in};
    end
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_rx,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              cs_assert,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);
    localparam int BIT_W = $clog2(BYTE_W + 1);

    spim_state_e        state;
    spim_dir_e          dir_q;
    logic [CNT_W-1:0]   left_q;
    logic [CNT_W-1:0]   fetch_q;
    logic [BYTE_W-1:0]  sh_q;
    logic [BIT_W-1:0]   bit_q;

    logic               tick;
    logic               buf_full, buf_wr, buf_rd;
    logic [BYTE_W-1:0]  buf_data;
    logic [BYTE_W-1:0]  rx_byte;
    logic               sample;
    logic               byte_end;

    assign busy     = (state != ST_IDLE);
    assign tx_ready = busy && (dir_q == DIR_TX) && !buf_full && (fetch_q != '0);
    assign buf_wr   = tx_ready && tx_valid;
    assign buf_rd   = (state == ST_LOAD) && (dir_q == DIR_TX) && buf_full;
    assign sample   = (state == ST_SHIFT) && tick && !sclk;
    assign byte_end = (state == ST_SHIFT) && tick && sclk && (bit_q == BIT_W'(BYTE_W));
    assign mosi     = sh_q[BYTE_W-1];

    spim_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (state == ST_SHIFT),
        .tick (tick)
    );

    spim_txbuf #(.W(BYTE_W)) u_txbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_wr),
        .wr_data (tx_data),
        .rd_en   (buf_rd),
        .full    (buf_full),
        .rd_data (buf_data)
    );

    spim_rxshift #(.W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample),
        .bit_in    (miso),
        .byte_out  (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            dir_q    <= DIR_TX;
            left_q   <= '0;
            fetch_q  <= '0;
            sh_q     <= FILL_BYTE;
            bit_q    <= '0;
            sclk     <= 1'b0;
            done     <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            cs_n     <= 1'b1;
        end else begin
            done     <= 1'b0;
            rx_valid <= 1'b0;
            cs_n     <= ~cs_assert;
            if (buf_wr) fetch_q <= fetch_q - 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (byte_count == '0) begin
                            done <= 1'b1;
                        end else begin
                            dir_q   <= dir_rx ? DIR_RX : DIR_TX;
                            left_q  <= byte_count;
                            fetch_q <= dir_rx ? '0 : byte_count;
                            sh_q    <= FILL_BYTE;
                            state   <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    bit_q <= '0;
                    if (dir_q == DIR_RX) begin
                        sh_q  <= FILL_BYTE;
                        state <= ST_SHIFT;
                    end else if (buf_full) begin
                        sh_q  <= buf_data;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            bit_q <= bit_q + 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (bit_q == BIT_W'(BYTE_W)) begin
                                rx_valid <= 1'b1;
                                rx_data  <= rx_byte;
                                left_q   <= left_q - 1'b1;
                                if (left_q == CNT_W'(1)) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    state <= ST_LOAD;
                                end
                            end else begin
                                sh_q <= shift_next(sh_q);
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the serial clock rests low outside a transfer
    assert_clk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R2: data out holds steady across a high clock phase
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R5: receive transfers drive ones and never ask for user data
    assert_rx_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && dir_q == DIR_RX) |-> (mosi && !tx_ready));

    // R6: completion of a real transfer coincides with the last received byte
    assert_done_with_rx_R6: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |-> rx_valid);

    // R8: a start during a transfer leaves the remaining count alone
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !byte_end) |=> (left_q == $past(left_q)));

    // R9: an empty request finishes at once without becoming busy
    assert_zero_count_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && byte_count == '0) |=> (done && !busy));

endmodule

// File: tb/tb_spi_stream_master.sv
`timescale 1ns/1ps
module tb_spi_stream_master;
    localparam int HALF = 4;
    localparam int CW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          dir_rx = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic          cs_assert = 1'b0;
    logic [7:0]    tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [7:0]    rx_data;
    logic          rx_valid, busy, done, sclk, mosi, cs_n;
    logic          miso;

    always #5 clk = ~clk;

    spi_stream_master #(.HALF_DIV(HALF), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .start(start), .dir_rx(dir_rx),
        .byte_count(byte_count), .cs_assert(cs_assert),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'h5A ^ 8'(i * 37 + 11);
    endfunction

    // ---------------- mode-0 slave model ----------------
    logic [7:0] sl_sh = 8'h00;
    logic [7:0] sl_cap = 8'h00;
    int sl_bit = 0, sl_idx = 0;
    logic [7:0] mo_log [32];
    int mo_n = 0;
    assign miso = sl_sh[7];

    always @(negedge cs_n) begin
        sl_idx = 0; sl_bit = 0; sl_sh = pat(0);
    end
    always @(posedge sclk) begin
        sl_cap = {sl_cap[6:0], mosi};
        sl_bit++;
        if (sl_bit == 8 && mo_n < 32) begin mo_log[mo_n] = sl_cap; mo_n++; end
    end
    always @(negedge sclk) begin
        if (sl_bit == 8) begin sl_bit = 0; sl_idx++; sl_sh = pat(sl_idx); end
        else sl_sh = {sl_sh[6:0], 1'b0};
    end

    // ---------------- monitors ----------------
    logic [7:0] rx_log [32];
    int rx_n = 0, done_n = 0, rx_at_done = -1, edges = 0, cyc = 0;
    int rise_cyc [2];
    int hold_bad = 0;
    logic p_sclk = 1'b0, p_mosi = 1'b1;

    always @(posedge clk) cyc++;
    always @(posedge sclk) begin
        if (edges < 2) rise_cyc[edges] = cyc;
        edges++;
    end
    always @(negedge clk) begin
        if (rx_valid && rx_n < 32) begin rx_log[rx_n] = rx_data; rx_n++; end
        if (done) begin done_n++; rx_at_done = rx_n; end
        if (sclk && p_sclk && mosi != p_mosi) hold_bad++;
        p_sclk = sclk; p_mosi = mosi;
    end

    task automatic clear_logs();
        rx_n = 0; mo_n = 0; done_n = 0; rx_at_done = -1; edges = 0;
    endtask

    task automatic pulse_start(input bit rx, input int n);
        @(negedge clk);
        start = 1'b1; dir_rx = rx; byte_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    int acc_edges [8];
    task automatic feed(input int first, input int n, input int gap_at, input int gap_len);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) begin
                @(negedge clk); tx_valid = 1'b0;
                repeat (gap_len) @(negedge clk);
            end
            @(negedge clk);
            tx_valid = 1'b1; tx_data = pat(first + i) ^ 8'hC3;
            while (!tx_ready) @(negedge clk);
            acc_edges[i] = edges;
            @(posedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_n < target && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic select(input bit on);
        @(negedge clk); cs_assert = on;
        @(negedge clk);
        chk(cs_n == !on, "R10 cs_n follows cs_assert", cs_n, !on);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(sclk == 0, "R1 sclk low", sclk, 0);
        chk(cs_n == 1, "R1 cs_n high", cs_n, 1);
        chk({busy, done, rx_valid, tx_ready} == 4'b0, "R1 outputs low",
            {busy, done, rx_valid, tx_ready}, 0);
    endtask

    task automatic t_send3();
        clear_logs();
        select(1);
        pulse_start(0, 3);
        feed(0, 3, -1, 0);
        wait_done(1);
        for (int i = 0; i < 3; i++)
            chk(mo_log[i] == (pat(i) ^ 8'hC3), "R3 byte on mosi", mo_log[i], pat(i) ^ 8'hC3);
        chk(rx_n == 3, "R4 rx count send", rx_n, 3);
        for (int i = 0; i < 3; i++)
            chk(rx_log[i] == pat(i), "R4 rx byte send", rx_log[i], pat(i));
        chk(done_n == 1 && rx_at_done == 3, "R6 done with last byte", rx_at_done, 3);
        chk(acc_edges[1] < 8, "R7 next byte accepted early", acc_edges[1], 7);
        chk(hold_bad == 0, "R2 mosi stable while sclk high", hold_bad, 0);
        select(0);
    endtask

    task automatic t_recv4();
        clear_logs();
        select(1);
        pulse_start(1, 4);
        repeat (3) begin
            @(negedge clk);
            chk(!tx_ready, "R5 no tx_ready in receive", tx_ready, 0);
        end
        wait_done(1);
        chk(rx_n == 4, "R4 rx count receive", rx_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(rx_log[i] == pat(i), "R4 rx byte receive", rx_log[i], pat(i));
            chk(mo_log[i] == 8'hFF, "R5 fill byte", mo_log[i], 8'hFF);
        end
        chk(rx_at_done == 4, "R6 done after final byte", rx_at_done, 4);
        chk(rise_cyc[1] - rise_cyc[0] == 2 * HALF, "R11 sclk period",
            rise_cyc[1] - rise_cyc[0], 2 * HALF);
        chk(!sclk && !busy, "R2 idle low after transfer", sclk, 0);
        select(0);
    endtask

    task automatic t_zero();
        clear_logs();
        @(negedge clk);
        start = 1'b1; dir_rx = 1'b0; byte_count = '0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1, "R9 done next cycle", done, 1);
        chk(busy == 0, "R9 never busy", busy, 0);
        repeat (20) @(negedge clk);
        chk(edges == 0, "R9 no clock edges", edges, 0);
    endtask

    task automatic t_busy_start();
        clear_logs();
        select(1);
        pulse_start(0, 2);
        fork
            feed(0, 2, -1, 0);
            begin
                repeat (10) @(negedge clk);
                start = 1'b1; dir_rx = 1'b1; byte_count = CW'(5);
                @(negedge clk);
                start = 1'b0;
            end
        join
        wait_done(1);
        repeat (300) @(negedge clk);
        chk(rx_n == 2 && done_n == 1, "R8 start while busy ignored", rx_n, 2);
        chk(edges == 16 && !busy, "R8 no extra clocks", edges, 16);
        select(0);
    endtask

    task automatic t_stall();
        clear_logs();
        select(1);
        pulse_start(0, 2);
        fork
            feed(4, 2, 1, 40 * HALF);
            begin
                repeat (30 * HALF) @(negedge clk);
                chk(edges == 8 && busy && !sclk, "R7 clock stalls without data", edges, 8);
            end
        join
        wait_done(1);
        chk(mo_log[0] == (pat(4) ^ 8'hC3) && mo_log[1] == (pat(5) ^ 8'hC3),
            "R7 bytes intact after stall", mo_log[1], pat(5) ^ 8'hC3);
        select(0);
    endtask

    task automatic t_chain();
        clear_logs();
        select(1);
        pulse_start(0, 1);
        feed(9, 1, -1, 0);
        wait_done(1);
        chk(cs_n == 0, "R10 select held between transfers", cs_n, 0);
        pulse_start(1, 2);
        wait_done(2);
        chk(rx_n == 3 && rx_log[1] == pat(1) && rx_log[2] == pat(2),
            "R10 chained transfer continues", rx_log[2], pat(2));
        select(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_send3();
        t_recv4();
        t_zero();
        t_busy_start();
        t_stall();
        t_chain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule